// File: doc/BRIEF.md
# Double-Ended Bundle Block Isolator

This block sits behind a byte-aligned instruction buffer. It splits one variable-length half-bundle into its operation blocks without parsing individual operations. Each bundle opens with a fixed header. The header gives the bundle's total length in bytes and an operation count for each of three blocks. All operations in one block share one width, so the length of a block is its count times that width.

The front block is cut from the bits just after the header, and the back block is cut from the bundle's last bits, working downward. Both are delivered in the same cycle, one cycle after the bundle arrives. The middle block is delivered one cycle later. The unused bits between the middle and back blocks form the alignment hole, which is presented on its own output for the no-op skip logic. The byte count is returned as a shift amount so that the buffer can move the next bundle into place. A header whose blocks do not fit inside the stated length raises an error and suppresses every block strobe for that bundle.

Top module: `bundle_block_isolator`

## Requirements
- R1: Bundle bit i is bit i%8 of byte i/8. The header occupies bits [16:0]: byte count in bits [7:0], front count in [10:8], middle count in [13:11], back count in [16:14]. Operation widths are 8 (front), 12 (middle) and 16 (back) bits. The counts are echoed on fr_cnt_o, mid_cnt_o and bk_cnt_o with their blocks.
- R2: One cycle after in_vld, fr_vld_o is high when the front count is nonzero and the bundle is valid. fr_data_o then holds bundle bits starting at bit 17, with length 8×count, zero-extended.
- R3: In the same cycle as the front block, bk_vld_o and bk_data_o carry the back block. This is the 16×count bits that end at bit 8×bytecount−1. Bytes beyond the byte count are ignored.
- R4: Two cycles after in_vld, mid_vld_o and mid_data_o carry the middle block. It holds 12×count bits starting just after the front block.
- R5: A block with count zero takes no bits and raises no strobe, and its data output is all zeros. Any data output is zero while its strobe is low.
- R6: One cycle after every in_vld, shift_vld_o is high and shift_bytes_o equals the header byte count, even when the bundle is in error.
- R7: err_o pulses one cycle after in_vld when 17 + the sum of block lengths exceeds 8×bytecount, or when the byte count exceeds 16. Such a bundle raises no block strobe in any cycle, and its hole outputs are zero.
- R8: With the front block, hole_len_o = 8×bytecount − 17 − the sum of block lengths. hole_bits_o holds the bits lying between the middle and back blocks, zero-extended.
- R9: Bundles presented on consecutive cycles each produce their own results in order, with no loss.
- R10: Synchronous active-high reset clears every strobe, count, data and error output, whatever in_vld does during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Bundle present at buffer head |
| in_bundle | input | 128 | Buffer head window, byte 0 in bits [7:0] |
| shift_vld_o | output | 1 | Shift amount valid |
| shift_bytes_o | output | 8 | Bytes to advance the buffer |
| err_o | output | 1 | Header inconsistent with byte count |
| fr_vld_o | output | 1 | Front block strobe |
| fr_cnt_o | output | 3 | Front block operation count |
| fr_data_o | output | 56 | Front block contents |
| bk_vld_o | output | 1 | Back block strobe |
| bk_cnt_o | output | 3 | Back block operation count |
| bk_data_o | output | 112 | Back block contents |
| hole_len_o | output | 13 | Alignment hole length in bits |
| hole_bits_o | output | 128 | Alignment hole contents |
| mid_vld_o | output | 1 | Middle block strobe |
| mid_cnt_o | output | 3 | Middle block operation count |
| mid_data_o | output | 84 | Middle block contents |

## Verification
The bundles tested have all three blocks populated, a single block populated, and only an empty header. These cases tell apart block boundaries taken from the right counts from boundaries shifted by a neighbour's length. A full-width front block and a full-width middle block show that masking stops at the block length. Bundles with junk above the byte count confirm that the back block is anchored at the stated end rather than at the window top. Three error cases are included: a length overrun by a single byte, an oversized byte count, and a back block that overruns the bundle. Two bundles sent back to back show that middle-block results are not mixed up between bundles.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  // bit length of a block with cnt operations of opw bits each
  function automatic int unsigned blk_bits(input int unsigned cnt, input int unsigned opw);
    return cnt * opw;
  endfunction
endpackage

// File: rtl/dbi_hdr_decode.sv
module dbi_hdr_decode #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 3,
  parameter int OPW_F     = 8,
  parameter int OPW_M     = 12,
  parameter int OPW_B     = 16,
  parameter int AW        = 13,
  localparam int HDR_W    = LEN_W + 3*CNT_W
) (
  input  logic [HDR_W-1:0] hdr,
  output logic [LEN_W-1:0] bytes,
  output logic [CNT_W-1:0] cnt_f,
  output logic [CNT_W-1:0] cnt_m,
  output logic [CNT_W-1:0] cnt_b,
  output logic [AW-1:0]    len_f,
  output logic [AW-1:0]    len_m,
  output logic [AW-1:0]    len_b,
  output logic [AW-1:0]    mid_start,
  output logic [AW-1:0]    hole_start,
  output logic [AW-1:0]    back_start,
  output logic [AW-1:0]    hole_len,
  output logic             bad
);
  logic [AW-1:0] tot;
  logic [AW-1:0] used;

  always_comb begin
    bytes      = hdr[LEN_W-1:0];
    cnt_f      = hdr[LEN_W +: CNT_W];
    cnt_m      = hdr[LEN_W+CNT_W +: CNT_W];
    cnt_b      = hdr[LEN_W+2*CNT_W +: CNT_W];
    len_f      = AW'(cnt_f) * AW'(OPW_F);
    len_m      = AW'(cnt_m) * AW'(OPW_M);
    len_b      = AW'(cnt_b) * AW'(OPW_B);
    tot        = AW'(bytes) << 3;
    used       = AW'(HDR_W) + len_f + len_m + len_b;
    bad        = (bytes > LEN_W'(MAX_BYTES)) || (used > tot);
    mid_start  = AW'(HDR_W) + len_f;
    hole_start = mid_start + len_m;
    back_start = tot - len_b;
    hole_len   = bad ? '0 : (tot - used);
  end
endmodule

// File: rtl/dbi_blk_extract.sv
module dbi_blk_extract #(
  parameter int IN_W  = 128,
  parameter int OUT_W = 56,
  parameter int AW    = 13
) (
  input  logic [IN_W-1:0]  src,
  input  logic [AW-1:0]    start,
  input  logic [AW-1:0]    len,
  output logic [OUT_W-1:0] dout
);
  logic [IN_W-1:0] sh;

  always_comb begin
    if (start >= AW'(IN_W)) sh = '0;
    else                    sh = src >> start;
  end

  for (genvar i = 0; i < OUT_W; i++) begin : g_mask
    assign dout[i] = (AW'(i) < len) ? sh[i] : 1'b0;
  end
endmodule

// File: rtl/bundle_block_isolator.sv
module bundle_block_isolator #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 3,
  parameter int OPW_F     = 8,
  parameter int OPW_M     = 12,
  parameter int OPW_B     = 16,
  localparam int BUN_W    = 8*MAX_BYTES,
  localparam int HDR_W    = LEN_W + 3*CNT_W,
  localparam int MAXCNT   = (1 << CNT_W) - 1,
  localparam int FW       = MAXCNT*OPW_F,
  localparam int MW       = MAXCNT*OPW_M,
  localparam int BW       = MAXCNT*OPW_B,
  localparam int AW       = LEN_W + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [BUN_W-1:0] in_bundle,
  output logic             shift_vld_o,
  output logic [LEN_W-1:0] shift_bytes_o,
  output logic             err_o,
  output logic             fr_vld_o,
  output logic [CNT_W-1:0] fr_cnt_o,
  output logic [FW-1:0]    fr_data_o,
  output logic             bk_vld_o,
  output logic [CNT_W-1:0] bk_cnt_o,
  output logic [BW-1:0]    bk_data_o,
  output logic [AW-1:0]    hole_len_o,
  output logic [BUN_W-1:0] hole_bits_o,
  output logic             mid_vld_o,
  output logic [CNT_W-1:0] mid_cnt_o,
  output logic [MW-1:0]    mid_data_o
);
  import dbi_pkg::*;

  logic [LEN_W-1:0] bytes;
  logic [CNT_W-1:0] cnt_f, cnt_m, cnt_b;
  logic [AW-1:0]    len_f, len_m, len_b;
  logic [AW-1:0]    mid_start, hole_start, back_start, hole_len;
  logic             bad, ok;
  logic [FW-1:0]    fdat;
  logic [BW-1:0]    bdat;
  logic [BUN_W-1:0] hdat;
  logic [MW-1:0]    mdat;

  // second-stage state for the middle block
  logic             mid_pend;
  logic [CNT_W-1:0] mid_cnt_q;
  logic [AW-1:0]    mid_len_q;
  logic [BUN_W-1:0] mid_rem;

  dbi_hdr_decode #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .OPW_F(OPW_F), .OPW_M(OPW_M), .OPW_B(OPW_B), .AW(AW)
  ) u_hdr (
    .hdr(in_bundle[HDR_W-1:0]), .bytes(bytes),
    .cnt_f(cnt_f), .cnt_m(cnt_m), .cnt_b(cnt_b),
    .len_f(len_f), .len_m(len_m), .len_b(len_b),
    .mid_start(mid_start), .hole_start(hole_start),
    .back_start(back_start), .hole_len(hole_len), .bad(bad)
  );

  assign ok = in_vld && !bad;

  // front block: right after the header
  dbi_blk_extract #(.IN_W(BUN_W), .OUT_W(FW), .AW(AW)) u_front (
    .src(in_bundle), .start(AW'(HDR_W)), .len(len_f), .dout(fdat));

  // back block: ends at the last stated byte
  dbi_blk_extract #(.IN_W(BUN_W), .OUT_W(BW), .AW(AW)) u_back (
    .src(in_bundle), .start(back_start), .len(len_b), .dout(bdat));

  // alignment hole between middle and back blocks
  dbi_blk_extract #(.IN_W(BUN_W), .OUT_W(BUN_W), .AW(AW)) u_hole (
    .src(in_bundle), .start(hole_start), .len(hole_len), .dout(hdat));

  // middle block: masked from the pre-shifted remainder in stage two
  dbi_blk_extract #(.IN_W(BUN_W), .OUT_W(MW), .AW(AW)) u_mid (
    .src(mid_rem), .start('0), .len(mid_len_q), .dout(mdat));

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_vld_o   <= 1'b0;
      shift_bytes_o <= '0;
      err_o         <= 1'b0;
      fr_vld_o      <= 1'b0;
      fr_cnt_o      <= '0;
      fr_data_o     <= '0;
      bk_vld_o      <= 1'b0;
      bk_cnt_o      <= '0;
      bk_data_o     <= '0;
      hole_len_o    <= '0;
      hole_bits_o   <= '0;
      mid_pend      <= 1'b0;
      mid_cnt_q     <= '0;
      mid_len_q     <= '0;
      mid_rem       <= '0;
    end else begin
      shift_vld_o   <= in_vld;
      shift_bytes_o <= in_vld ? bytes : '0;
      err_o         <= in_vld && bad;
      fr_vld_o      <= ok && (cnt_f != '0);
      fr_cnt_o      <= ok ? cnt_f : '0;
      fr_data_o     <= ok ? fdat : '0;
      bk_vld_o      <= ok && (cnt_b != '0);
      bk_cnt_o      <= ok ? cnt_b : '0;
      bk_data_o     <= ok ? bdat : '0;
      hole_len_o    <= ok ? hole_len : '0;
      hole_bits_o   <= ok ? hdat : '0;
      mid_pend      <= ok && (cnt_m != '0);
      mid_cnt_q     <= ok ? cnt_m : '0;
      mid_len_q     <= ok ? len_m : '0;
      mid_rem       <= ok ? (in_bundle >> mid_start) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_vld_o  <= 1'b0;
      mid_cnt_o  <= '0;
      mid_data_o <= '0;
    end else begin
      mid_vld_o  <= mid_pend;
      mid_cnt_o  <= mid_cnt_q;
      mid_data_o <= mid_pend ? mdat : '0;
    end
  end

  localparam int CW = AW + 2;

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!fr_vld_o && !bk_vld_o && hole_len_o == '0));

  // R6
  shift_tracks_in_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_vld)) |-> (shift_vld_o && shift_bytes_o == $past(in_bundle[LEN_W-1:0])));

  // R4
  mid_after_front_chk: assert property (@(posedge clk) disable iff (rst)
    mid_vld_o |-> ($past(shift_vld_o) && !$past(err_o)));

  // R5
  fr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !fr_vld_o |-> (fr_data_o == '0));

  // R8
  hole_fit_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_vld_o && !err_o) |->
      ((CW'(hole_len_o) + CW'(HDR_W) + CW'(fr_cnt_o)*CW'(OPW_F) + CW'(bk_cnt_o)*CW'(OPW_B))
        <= (CW'(shift_bytes_o) << 3)));
endmodule

// File: tb/bundle_block_isolator_tb_top.sv
module bundle_block_isolator_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [127:0] bun;
    logic         err;
    logic         fv, mv, bv;
    logic [2:0]   c0, c1, c2;
    logic [55:0]  fd;
    logic [83:0]  md;
    logic [111:0] bd;
    logic [12:0]  hl;
    logic [127:0] hb;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [127:0] in_bundle = '0;
  logic         shift_vld_o, err_o, fr_vld_o, bk_vld_o, mid_vld_o;
  logic [7:0]   shift_bytes_o;
  logic [2:0]   fr_cnt_o, bk_cnt_o, mid_cnt_o;
  logic [55:0]  fr_data_o;
  logic [111:0] bk_data_o;
  logic [83:0]  mid_data_o;
  logic [12:0]  hole_len_o;
  logic [127:0] hole_bits_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_block_isolator dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_bundle(in_bundle),
    .shift_vld_o(shift_vld_o), .shift_bytes_o(shift_bytes_o), .err_o(err_o),
    .fr_vld_o(fr_vld_o), .fr_cnt_o(fr_cnt_o), .fr_data_o(fr_data_o),
    .bk_vld_o(bk_vld_o), .bk_cnt_o(bk_cnt_o), .bk_data_o(bk_data_o),
    .hole_len_o(hole_len_o), .hole_bits_o(hole_bits_o),
    .mid_vld_o(mid_vld_o), .mid_cnt_o(mid_cnt_o), .mid_data_o(mid_data_o));

  // bc, front count, middle count, back count
  localparam logic [31:0] VEC [10] = '{
    {8'd16, 8'd2, 8'd3, 8'd2}, {8'd8,  8'd1, 8'd0, 8'd1},
    {8'd12, 8'd0, 8'd2, 8'd3}, {8'd5,  8'd0, 8'd0, 8'd0},
    {8'd16, 8'd7, 8'd0, 8'd0}, {8'd16, 8'd0, 8'd0, 8'd7},
    {8'd20, 8'd0, 8'd0, 8'd0}, {8'd3,  8'd1, 8'd0, 8'd0},
    {8'd3,  8'd0, 8'd0, 8'd0}, {8'd14, 8'd0, 8'd7, 8'd0}};

  function automatic logic [127:0] pat(input int s, input int k);
    logic [31:0] w;
    w = 32'(s) * 32'h9E3779B1 + 32'(k) * 32'h7F4A7C15;
    return {w, ~w, w ^ 32'hA5A5A5A5, w + 32'd1};
  endfunction

  function automatic logic [127:0] msk(input logic [127:0] v, input int len);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < len; i++) r[i] = v[i];
    return r;
  endfunction

  // build a bundle from chosen block contents and derive the expected outputs
  function automatic exp_t make(input int bc, input int c0, input int c1, input int c2, input int s);
    exp_t e;
    int lf, lm, lb, hl;
    logic [127:0] fp, mp, bp, hp;
    lf = c0*8; lm = c1*12; lb = c2*16;
    fp = pat(s, 1); mp = pat(s, 2); bp = pat(s, 3); hp = pat(s, 4);
    e = '0;
    e.bun = pat(s, 9);
    e.bun[7:0] = 8'(bc);
    e.bun[10:8] = 3'(c0);
    e.bun[13:11] = 3'(c1);
    e.bun[16:14] = 3'(c2);
    e.err = ((17 + lf + lm + lb) > 8*bc) || (bc > 16);
    if (!e.err) begin
      hl = 8*bc - 17 - lf - lm - lb;
      for (int i = 0; i < lf; i++) e.bun[17+i] = fp[i];
      for (int i = 0; i < lm; i++) e.bun[17+lf+i] = mp[i];
      for (int i = 0; i < hl; i++) e.bun[17+lf+lm+i] = hp[i];
      for (int i = 0; i < lb; i++) e.bun[8*bc-lb+i] = bp[i];
      e.fv = (c0 != 0); e.mv = (c1 != 0); e.bv = (c2 != 0);
      e.c0 = 3'(c0); e.c1 = 3'(c1); e.c2 = 3'(c2);
      e.fd = 56'(msk(fp, lf));
      e.md = 84'(msk(mp, lm));
      e.bd = 112'(msk(bp, lb));
      e.hl = 13'(hl);
      e.hb = msk(hp, hl);
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_stage1(input exp_t e, input logic [7:0] bc);
    chk("R6 shift_vld", 128'(shift_vld_o), 128'(1));
    chk("R6 shift_bytes", 128'(shift_bytes_o), 128'(bc));
    chk("R7 err", 128'(err_o), 128'(e.err));
    chk("R2 fr_vld", 128'(fr_vld_o), 128'(e.fv));
    chk("R1 fr_cnt", 128'(fr_cnt_o), 128'(e.c0));
    chk("R2 R5 fr_data", 128'(fr_data_o), 128'(e.fd));
    chk("R3 bk_vld", 128'(bk_vld_o), 128'(e.bv));
    chk("R1 bk_cnt", 128'(bk_cnt_o), 128'(e.c2));
    chk("R3 R5 bk_data", 128'(bk_data_o), 128'(e.bd));
    chk("R8 hole_len", 128'(hole_len_o), 128'(e.hl));
    chk("R8 hole_bits", hole_bits_o, e.hb);
  endtask

  task automatic chk_stage2(input exp_t e);
    chk("R4 mid_vld", 128'(mid_vld_o), 128'(e.mv));
    chk("R1 mid_cnt", 128'(mid_cnt_o), 128'(e.c1));
    chk("R4 R5 mid_data", 128'(mid_data_o), 128'(e.md));
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, 128'({shift_vld_o, err_o, fr_vld_o, bk_vld_o, mid_vld_o}), 128'(0));
    chk(tag, fr_data_o ^ 128'(bk_data_o) ^ 128'(mid_data_o) ^ hole_bits_o, 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t e, e2;
    // R10: reset holds outputs clear even with a bundle offered
    e = make(16, 2, 3, 2, 77);
    @(negedge clk);
    in_vld = 1'b1; in_bundle = e.bun;
    repeat (3) @(negedge clk);
    chk_idle("R10 reset");
    in_vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R10 after reset");

    // table walk
    for (int v = 0; v < 10; v++) begin
      e = make(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), v+1);
      in_vld = 1'b1; in_bundle = e.bun;
      @(negedge clk);
      in_vld = 1'b0; in_bundle = '0;
      chk_stage1(e, VEC[v][31:24]);
      @(negedge clk);
      chk_stage2(e);
      chk("R7 quiet after", 128'({shift_vld_o, err_o, fr_vld_o, bk_vld_o}), 128'(0));
    end

    // R9: back-to-back bundles
    e  = make(16, 2, 3, 2, 31);
    e2 = make(12, 0, 2, 3, 32);
    in_vld = 1'b1; in_bundle = e.bun;
    @(negedge clk);
    in_bundle = e2.bun;
    chk_stage1(e, 8'd16);
    @(negedge clk);
    in_vld = 1'b0; in_bundle = '0;
    chk_stage2(e);
    chk_stage1(e2, 8'd12);
    @(negedge clk);
    chk_stage2(e2);
    chk("R9 order", 128'(mid_data_o), 128'(e2.md));

    // R7: error bundle followed by good one leaves no middle strobe from the error
    e  = make(3, 1, 1, 0, 40);
    e2 = make(8, 1, 0, 1, 41);
    in_vld = 1'b1; in_bundle = e.bun;
    @(negedge clk);
    in_bundle = e2.bun;
    chk("R7 err pulse", 128'(err_o), 128'(1));
    @(negedge clk);
    in_vld = 1'b0;
    chk("R7 no mid strobe", 128'(mid_vld_o), 128'(0));
    chk_stage1(e2, 8'd8);

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule